// File: doc/BRIEF.md
# Processor Control-Pin Interrupt Front-End

This block sits between a processor's control input pins and its core. It samples a parallel pin vector on every clock and compares each pin with the level it stored on the previous clock. Only a real change of level causes an action. Each pin has its own meaning, sensitivity and polarity:

- timebase run control: level, active high
- external and system-management interrupts: level, active high
- machine check: falling edge only
- checkstop: level, active low
- hard reset: active low
- soft-reset interrupt: level
- all other pin positions: no function

The block has five kinds of output. It keeps a four-bit pending-interrupt vector and drives a combined hard-interrupt request from it. It also drives a timebase run flag, a sticky core-stop flag and a one-cycle system reset request. The machine-check source is the only edge-type interrupt source. Its pending bit stays set until an acknowledge input clears it. The level-type pending bits follow their pins.

Pin inputs are assumed to be synchronous to `clk` already. The asynchronous reset is released through a two-stage synchroniser, so the block starts reacting two clocks after `rst_n` rises.

Top module: `ctlpin_irq_front`

## Requirements
- R1: A pin is acted on only in the clock where its sampled level differs from the stored level of the previous clock. Holding a level steady produces no further event. After reset, the stored levels are 1 for pins 4 and 5 and 0 for all other pins.
- R2: Pin 0 is timebase enable. When it changes to high, `tb_run` becomes 1. When it changes to low, `tb_run` becomes 0.
- R3: Pin 1 is the external interrupt and pin 2 is the system-management interrupt. On each change of level, `pend[0]` (for pin 1) or `pend[1]` (for pin 2) takes the new pin level.
- R4: Pin 3 is machine check. A 1-to-0 transition sets `pend[2]`, and a 0-to-1 transition has no effect.
- R5: Pin 4 is checkstop, active low. A change to 0 sets `core_stop`. `core_stop` then stays 1 until reset, whatever pin 4 does afterwards.
- R6: Pin 5 is hard reset, active low. A change to 0 raises `sys_rst_req` for exactly one clock.
- R7: Pin 6 is soft reset. On each change of level, `pend[3]` takes the new pin level.
- R8: `hard_req` is 1 exactly when at least one bit of `pend` is set, and it is updated in the same clock as `pend`.
- R9: A level change on a pin with no function (pin 7 and above) changes no output.
- R10: `ack[2]` clears `pend[2]`. An `ack` bit for a level-type source (bits 0, 1, 3) has no effect.
- R11: If a machine-check falling edge and `ack[2]` occur in the same clock, `pend[2]` ends up set.
- R12: While reset is active, and in the first clock after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | NPINS (8) | Control pin levels, already synchronous to `clk` |
| ack | input | 4 | Per-source acknowledge; only the edge-type bit 2 acts |
| pend | output | 4 | Pending interrupts: bit 0 external, bit 1 system management, bit 2 machine check, bit 3 soft reset |
| hard_req | output | 1 | OR of all pending bits |
| tb_run | output | 1 | Timebase runs when 1 and is frozen when 0 |
| core_stop | output | 1 | Core stopped; stays set until reset |
| sys_rst_req | output | 1 | One-clock system reset request |

## Verification
The pin vector is walked through three kinds of pattern, and each separates one class of fault:

- **Repeated equal levels.** These show whether change detection works, or whether the block reacts to the level alone.
- **Rising and falling steps on each pin.** These separate the level-following sources from the falling-edge machine check and from the sticky active-low stop.
- **Toggles of a pin with no function, and acknowledges aimed at level-type sources.** These show that no unintended path exists.

Directed cases then drive an edge and an acknowledge in the same clock, hold hard reset low for several clocks to check that the request is a single pulse, and release checkstop to check that the stop is sticky.

// File: rtl/cpfe_pkg.sv
package cpfe_pkg;
  // Pin positions inside the input vector.
  localparam int PIN_TBEN  = 0;
  localparam int PIN_EXT   = 1;
  localparam int PIN_SMI   = 2;
  localparam int PIN_MCHK  = 3;
  localparam int PIN_CSTOP = 4;
  localparam int PIN_HRST  = 5;
  localparam int PIN_SRST  = 6;
  localparam int NDEF      = 7;

  // Pending-vector bit positions.
  localparam int NSRC     = 4;
  localparam int SRC_EXT  = 0;
  localparam int SRC_SMI  = 1;
  localparam int SRC_MCHK = 2;
  localparam int SRC_SRST = 3;

  // Sources that are edge type and therefore need an acknowledge to clear.
  localparam logic [NSRC-1:0] EDGE_SRC = 4'b0100;

  typedef struct packed {
    logic [NSRC-1:0] set;
    logic [NSRC-1:0] clr;
  } pend_upd_t;
endpackage

// File: rtl/cpfe_pin_track.sv
module cpfe_pin_track #(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] IDLE_LVL = '0,
  parameter int NOUT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  output logic [NOUT-1:0]  rise,
  output logic [NOUT-1:0]  fall
);
  logic [NPINS-1:0] last_q;
  logic [NPINS-1:0] last_d;
  logic [NPINS-1:0] chg;

  always_comb begin
    chg    = pins ^ last_q;
    last_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDLE_LVL;
    else        last_q <= last_d;
  end

  for (genvar i = 0; i < NOUT; i++) begin : g_dir
    assign rise[i] = chg[i] &  pins[i];
    assign fall[i] = chg[i] & ~pins[i];
  end
endmodule

// File: rtl/cpfe_pend.sv
module cpfe_pend #(
  parameter int NSRC = 4,
  parameter logic [NSRC-1:0] EDGE_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_v,
  input  logic [NSRC-1:0] lvl_clr,
  input  logic [NSRC-1:0] ack,
  output logic [NSRC-1:0] pend,
  output logic            any_req
);
  logic [NSRC-1:0] pend_q, pend_d, clr_eff;
  logic            req_q, req_d;

  always_comb clr_eff = (lvl_clr & ~EDGE_MASK) | (ack & EDGE_MASK);

  // The set term is ORed in last, so a set wins over a clear in the same clock.
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb pend_d[i] = set_v[i] | (pend_q[i] & ~clr_eff[i]);
  end

  always_comb req_d = |pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
    end
  end

  assign pend    = pend_q;
  assign any_req = req_q;
endmodule

// File: rtl/cpfe_ctrl.sv
module cpfe_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tb_up,
  input  logic tb_dn,
  input  logic cstop_act,
  input  logic hrst_act,
  output logic tb_run,
  output logic core_stop,
  output logic sys_rst_req
);
  logic tb_q, tb_d, stop_q, stop_d, rreq_q, rreq_d;
  logic tb_en;

  always_comb begin
    tb_en  = tb_up | tb_dn;
    tb_d   = tb_up;
    stop_d = stop_q | cstop_act;
    rreq_d = hrst_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q   <= 1'b0;
      stop_q <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      if (tb_en) tb_q <= tb_d;
      stop_q <= stop_d;
      rreq_q <= rreq_d;
    end
  end

  assign tb_run      = tb_q;
  assign core_stop   = stop_q;
  assign sys_rst_req = rreq_q;
endmodule

// File: rtl/ctlpin_irq_front.sv
module ctlpin_irq_front
  import cpfe_pkg::*;
#(
  parameter int NPINS = 8,
  parameter logic [NPINS-1:0] IDLE_LVL = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [3:0]       ack,
  output logic [3:0]       pend,
  output logic             hard_req,
  output logic             tb_run,
  output logic             core_stop,
  output logic             sys_rst_req
);
  logic [1:0]      rst_sync_q;
  logic            rst_sync_n;
  logic [NDEF-1:0] rise, fall;
  pend_upd_t       upd;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  cpfe_pin_track #(.NPINS(NPINS), .IDLE_LVL(IDLE_LVL), .NOUT(NDEF)) u_track (
    .clk(clk), .rst_n(rst_sync_n), .pins(pins), .rise(rise), .fall(fall)
  );

  always_comb begin
    upd = '0;
    upd.set[SRC_EXT]  = rise[PIN_EXT];
    upd.clr[SRC_EXT]  = fall[PIN_EXT];
    upd.set[SRC_SMI]  = rise[PIN_SMI];
    upd.clr[SRC_SMI]  = fall[PIN_SMI];
    upd.set[SRC_MCHK] = fall[PIN_MCHK];
    upd.set[SRC_SRST] = rise[PIN_SRST];
    upd.clr[SRC_SRST] = fall[PIN_SRST];
  end

  cpfe_pend #(.NSRC(NSRC), .EDGE_MASK(EDGE_SRC)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .set_v(upd.set), .lvl_clr(upd.clr),
    .ack(ack), .pend(pend), .any_req(hard_req)
  );

  cpfe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .tb_up(rise[PIN_TBEN]), .tb_dn(fall[PIN_TBEN]),
    .cstop_act(fall[PIN_CSTOP]), .hrst_act(fall[PIN_HRST]),
    .tb_run(tb_run), .core_stop(core_stop), .sys_rst_req(sys_rst_req)
  );

  // Observe-only inputs and locally unused signals of the other rise/fall bits.
  logic unused_ok;
  assign unused_ok = &{1'b0, rise[PIN_MCHK], rise[PIN_CSTOP], rise[PIN_HRST]};
endmodule

// File: rtl/ctlpin_irq_front_chk.sv
module ctlpin_irq_front_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] pins,
  input logic [3:0]       ack,
  input logic [3:0]       pend,
  input logic             hard_req,
  input logic             tb_run,
  input logic             core_stop,
  input logic             sys_rst_req
);
  AST_REQ_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    hard_req == (pend != 4'b0)); // R8
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop |=> core_stop); // R5
  AST_RST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req); // R6
  AST_MCHK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[2] && !ack[2]) |=> pend[2]); // R4
  AST_EXT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins[1]) |=> pend[0]); // R3
  AST_EXT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins[1]) |=> !pend[0]); // R3
  AST_TB_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins[0]) |=> tb_run); // R2
endmodule

bind ctlpin_irq_front ctlpin_irq_front_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .pins(pins), .ack(ack), .pend(pend),
  .hard_req(hard_req), .tb_run(tb_run), .core_stop(core_stop),
  .sys_rst_req(sys_rst_req)
);

// File: tb/sim_ctlpin_irq_front.sv
`timescale 1ns/1ps
module sim_ctlpin_irq_front;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pins;
  logic [3:0] ack;
  logic [3:0] pend;
  logic       hard_req, tb_run, core_stop, sys_rst_req;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ctlpin_irq_front u0 (
    .clk(clk), .rst_n(rst_n), .pins(pins), .ack(ack), .pend(pend),
    .hard_req(hard_req), .tb_run(tb_run), .core_stop(core_stop),
    .sys_rst_req(sys_rst_req)
  );

  // Vector fields: pins, ack, expected pend, expected tb_run, expected stop, expected reset request.
  typedef struct packed {
    logic [7:0] p;
    logic [3:0] a;
    logic [3:0] ep;
    logic       etb;
    logic       est;
    logic       err;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{8'h31, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R2 timebase start
    '{8'h31, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R1 level held
    '{8'h33, 4'h0, 4'h1, 1'b1, 1'b0, 1'b0},  // R3 external set, R8
    '{8'h37, 4'h0, 4'h3, 1'b1, 1'b0, 1'b0},  // R3 system management set
    '{8'h33, 4'h0, 4'h1, 1'b1, 1'b0, 1'b0},  // R3 system management clear
    '{8'h3B, 4'h0, 4'h1, 1'b1, 1'b0, 1'b0},  // R4 rising machine check ignored
    '{8'h33, 4'h0, 4'h5, 1'b1, 1'b0, 1'b0},  // R4 falling machine check sets
    '{8'h33, 4'h1, 4'h5, 1'b1, 1'b0, 1'b0},  // R10 ack on level source ignored
    '{8'h31, 4'h0, 4'h4, 1'b1, 1'b0, 1'b0},  // R3 external clear
    '{8'h31, 4'h4, 4'h0, 1'b1, 1'b0, 1'b0},  // R10 ack clears, R8 request drops
    '{8'h71, 4'h0, 4'h8, 1'b1, 1'b0, 1'b0},  // R7 soft reset set
    '{8'h31, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R7 soft reset clear
    '{8'hB1, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R9 unused pin
    '{8'h31, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0},  // R9 unused pin back
    '{8'h30, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0}   // R2 timebase freeze
  };

  task automatic chk(input string req, input logic [3:0] ep, input logic etb,
                     input logic est, input logic err);
    logic [7:0] act, exp;
    act = {pend, hard_req, tb_run, core_stop, sys_rst_req};
    exp = {ep, (ep != 4'h0), etb, est, err};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (pend,req,tb,stop,rst)", req, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] p, input logic [3:0] a);
    pins = p;
    ack  = a;
    @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    pins  = 8'h30;
    ack   = 4'h0;
    repeat (3) @(negedge clk);
    chk("R12 in reset", 4'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after release", 4'h0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VT[i].p, VT[i].a);
      chk($sformatf("R1/vector %0d", i), VT[i].ep, VT[i].etb, VT[i].est, VT[i].err);
    end

    // R11: falling machine-check edge and acknowledge in the same clock.
    step(8'h38, 4'h0);
    chk("R11 setup", 4'h0, 1'b0, 1'b0, 1'b0);
    step(8'h30, 4'h4);
    chk("R11 set wins", 4'h4, 1'b0, 1'b0, 1'b0);
    step(8'h30, 4'h4);
    chk("R10 ack clears", 4'h0, 1'b0, 1'b0, 1'b0);

    // R6: hard reset held low gives one pulse.
    step(8'h10, 4'h0);
    chk("R6 pulse", 4'h0, 1'b0, 1'b0, 1'b1);
    step(8'h10, 4'h0);
    chk("R6 single", 4'h0, 1'b0, 1'b0, 1'b0);
    step(8'h30, 4'h0);
    chk("R6 release", 4'h0, 1'b0, 1'b0, 1'b0);

    // R5: checkstop is sticky.
    step(8'h20, 4'h0);
    chk("R5 stop", 4'h0, 1'b0, 1'b1, 1'b0);
    step(8'h30, 4'h0);
    chk("R5 sticky", 4'h0, 1'b0, 1'b1, 1'b0);

    // R12: reset clears the stop.
    do_reset();

    // R1: a level present while in reset equal to the idle level gives no event.
    step(8'h30, 4'h0);
    chk("R1 idle", 4'h0, 1'b0, 1'b0, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule